// File: doc/BRIEF.md
# Conditional-Move Integer Pipeline Slice

This block is a four-stage in-order integer pipeline slice: operand read, execute, a pass-through memory stage, and writeback. It runs two operations over an eight-entry, 32-bit register file. The first is a register add. The second is a move-if-zero: the destination takes the first source when the second source is zero, and otherwise keeps its own value. Instructions arrive one per cycle with a valid strobe. Every retiring write appears on a commit port. A debug port reads the architectural registers.

The move-if-zero reads three registers: the candidate source, the condition, and the current destination. Execute tests the condition for zero and picks between the candidate and the old destination value. The picked value then travels down the pipe like any add result, and the register file is always written with it. Because the outcome is settled in execute, the next instruction can read it at once through the forwarding muxes. Those muxes sit on all three source operands, including the old-destination operand. The pipeline never stalls.

There is no state machine. Each operand has a small selector that settles in one cycle. It picks one of four sources: zero, the execute/memory result, the memory/writeback result, or the register file.

Top module: `cmov_pipe`

## Requirements
- R1: While reset is held and in the first cycle after it, no commit is reported. After reset, register i reads the value i on the debug port, so register 0 reads 0.
- R2: When `in_op` = 0, the instruction is an add: rd receives rs + rt. Each valid instruction that names a nonzero rd appears on the commit port exactly three rising edges after the edge that captures it, with the same rd, and commits come out in program order.
- R3: When `in_op` = 1, the instruction is move-if-zero. If register rt holds zero, rd receives the value of rs.
- R4: For a move-if-zero whose rt is nonzero, rd is still written and committed, and the value written is rd's previous value.
- R5: An instruction issued in the cycle right after a move-if-zero, and reading that move's rd as any operand, gets the resolved value for both the taken and the not-taken outcome.
- R6: Forwarding gives priority to the youngest producer. The execute/memory result wins over the memory/writeback result, which wins over the register file. This holds for the rs, rt and old-rd operands alike.
- R7: A producer issued three slots ahead of a consumer is seen by that consumer, because the register file passes a same-cycle write through to its reads.
- R8: Register 0 always reads as zero. A write to it is dropped and never committed, and no forwarded value ever replaces a read of it.
- R9: A cycle with `in_valid` low commits nothing and forwards nothing, whatever values sit on the instruction fields.
- R10: The debug port returns the committed contents of the addressed register. A commit becomes visible there from the cycle after it is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction on the in_* fields is real |
| in_op | input | 1 | 0 = add, 1 = move-if-zero |
| in_rd | input | 3 | Destination register index |
| in_rs | input | 3 | Candidate / first source index |
| in_rt | input | 3 | Condition / second source index |
| dbg_addr | input | 3 | Debug read index |
| dbg_data | output | 32 | Debug read value |
| wb_valid | output | 1 | A register write retires this cycle |
| wb_rd | output | 3 | Index of the retiring write |
| wb_data | output | 32 | Value of the retiring write |

## Verification
Two things can land in the same cycle here. A move-if-zero resolves its own condition while its old-destination operand is taken from a forwarding path. Separately, one source can match both the execute/memory and the memory/writeback producers at once. The bench sets up the first case by writing a register and then issuing, back to back, a move-if-zero that keeps or replaces that register, followed by a consumer of it. It sets up the second by writing the same register twice in a row and reading it at once. A scoreboard built from a sequential model judges every commit in order. Debug reads after each program is drained confirm the architectural state.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    // Operation code carried on in_op.
    typedef enum logic {
        OP_ADD   = 1'b0,
        OP_CMOVZ = 1'b1
    } op_e;

    // Source picked by one operand forwarding selector.
    typedef enum logic [1:0] {
        SRC_FILE = 2'd0,
        SRC_NEAR = 2'd1,
        SRC_FAR  = 2'd2,
        SRC_ZERO = 2'd3
    } fwd_src_e;

endpackage

// File: rtl/cmp_regfile.sv
module cmp_regfile #(
    parameter int DATA_W = 32,
    parameter int REG_N  = 8,
    parameter int RPORTS = 3,
    localparam int AW    = $clog2(REG_N)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [AW-1:0]                  waddr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [RPORTS-1:0][AW-1:0]      raddr,
    output logic [RPORTS-1:0][DATA_W-1:0]  rdata,
    input  logic [AW-1:0]                  dbg_addr,
    output logic [DATA_W-1:0]              dbg_data
);

    logic [DATA_W-1:0] cells [REG_N];

    // Register 0 is hard-wired; the others reset to their own index.
    for (genvar g = 0; g < REG_N; g++) begin : g_cell
        if (g == 0) begin : g_zero
            assign cells[g] = '0;
        end else begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cells[g] <= DATA_W'(g);
                end else if (we && waddr == AW'(g)) begin
                    cells[g] <= wdata;
                end
            end
        end
    end

    // Read ports pass a same-cycle write straight through.
    for (genvar p = 0; p < RPORTS; p++) begin : g_rport
        always_comb begin
            if (raddr[p] == '0) begin
                rdata[p] = '0;
            end else if (we && waddr == raddr[p]) begin
                rdata[p] = wdata;
            end else begin
                rdata[p] = cells[raddr[p]];
            end
        end
    end

    assign dbg_data = cells[dbg_addr];

endmodule

// File: rtl/cmp_fwd.sv
module cmp_fwd
    import cmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 3
) (
    input  logic [AW-1:0]     src_idx,
    input  logic [DATA_W-1:0] file_val,
    input  logic              near_we,
    input  logic [AW-1:0]     near_rd,
    input  logic [DATA_W-1:0] near_val,
    input  logic              far_we,
    input  logic [AW-1:0]     far_rd,
    input  logic [DATA_W-1:0] far_val,
    output logic [DATA_W-1:0] opnd
);

    fwd_src_e pick;

    // Youngest producer first; register 0 never takes a forwarded value.
    always_comb begin
        if (src_idx == '0) begin
            pick = SRC_ZERO;
        end else if (near_we && near_rd == src_idx) begin
            pick = SRC_NEAR;
        end else if (far_we && far_rd == src_idx) begin
            pick = SRC_FAR;
        end else begin
            pick = SRC_FILE;
        end
    end

    always_comb begin
        unique case (pick)
            SRC_ZERO: opnd = '0;
            SRC_NEAR: opnd = near_val;
            SRC_FAR:  opnd = far_val;
            SRC_FILE: opnd = file_val;
        endcase
    end

endmodule

// File: rtl/cmp_exec.sv
module cmp_exec
    import cmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] src_old,
    output logic [DATA_W-1:0] result
);

    logic cond_zero;

    assign cond_zero = (src_b == '0);

    always_comb begin
        unique case (op)
            OP_ADD:   result = src_a + src_b;
            OP_CMOVZ: result = cond_zero ? src_a : src_old;
        endcase
    end

endmodule

// File: rtl/cmov_pipe.sv
module cmov_pipe
    import cmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_N  = 8,
    localparam int AW    = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic [AW-1:0]     in_rd,
    input  logic [AW-1:0]     in_rs,
    input  logic [AW-1:0]     in_rt,
    input  logic [AW-1:0]     dbg_addr,
    output logic [DATA_W-1:0] dbg_data,
    output logic              wb_valid,
    output logic [AW-1:0]     wb_rd,
    output logic [DATA_W-1:0] wb_data
);

    // Operand slots: 0 = rs (candidate), 1 = rt (condition), 2 = old rd.
    localparam int NSRC = 3;

    typedef struct packed {
        logic                         live;
        op_e                          op;
        logic [AW-1:0]                rd;
        logic [NSRC-1:0][AW-1:0]      idx;
        logic [NSRC-1:0][DATA_W-1:0]  val;
    } ex_slot_t;

    typedef struct packed {
        logic              we;
        logic [AW-1:0]     rd;
        logic [DATA_W-1:0] val;
    } res_slot_t;

    ex_slot_t                     ex_q;
    res_slot_t                    mem_q;
    res_slot_t                    wb_q;
    logic [NSRC-1:0][AW-1:0]      rd_idx;
    logic [NSRC-1:0][DATA_W-1:0]  file_val;
    logic [NSRC-1:0][DATA_W-1:0]  fwd_val;
    logic [DATA_W-1:0]            ex_res;

    assign rd_idx[0] = in_rs;
    assign rd_idx[1] = in_rt;
    assign rd_idx[2] = in_rd;

    cmp_regfile #(
        .DATA_W (DATA_W),
        .REG_N  (REG_N),
        .RPORTS (NSRC)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wb_q.we),
        .waddr    (wb_q.rd),
        .wdata    (wb_q.val),
        .raddr    (rd_idx),
        .rdata    (file_val),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

    for (genvar k = 0; k < NSRC; k++) begin : g_fwd
        cmp_fwd #(
            .DATA_W (DATA_W),
            .AW     (AW)
        ) u_fwd (
            .src_idx  (ex_q.idx[k]),
            .file_val (ex_q.val[k]),
            .near_we  (mem_q.we),
            .near_rd  (mem_q.rd),
            .near_val (mem_q.val),
            .far_we   (wb_q.we),
            .far_rd   (wb_q.rd),
            .far_val  (wb_q.val),
            .opnd     (fwd_val[k])
        );
    end

    cmp_exec #(
        .DATA_W (DATA_W)
    ) u_exec (
        .op      (ex_q.op),
        .src_a   (fwd_val[0]),
        .src_b   (fwd_val[1]),
        .src_old (fwd_val[2]),
        .result  (ex_res)
    );

    // Operand read -> execute.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_q <= '0;
        end else begin
            ex_q.live <= in_valid;
            ex_q.op   <= op_e'(in_op);
            ex_q.rd   <= in_rd;
            ex_q.idx  <= rd_idx;
            ex_q.val  <= file_val;
        end
    end

    // Execute -> memory pass -> writeback; the move is already resolved here.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
            wb_q  <= '0;
        end else begin
            mem_q.we  <= ex_q.live && (ex_q.rd != '0);
            mem_q.rd  <= ex_q.rd;
            mem_q.val <= ex_res;
            wb_q      <= mem_q;
        end
    end

    assign wb_valid = wb_q.we;
    assign wb_rd    = wb_q.rd;
    assign wb_data  = wb_q.val;

endmodule

// File: rtl/cmov_pipe_chk.sv
module cmov_pipe_chk #(
    parameter int DATA_W = 32,
    parameter int AW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [AW-1:0]     in_rd,
    input logic [AW-1:0]     dbg_addr,
    input logic [DATA_W-1:0] dbg_data,
    input logic              wb_valid,
    input logic [AW-1:0]     wb_rd,
    input logic [DATA_W-1:0] wb_data
);

    // R1
    first_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !wb_valid);

    // R2
    commit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(in_valid, 3) && $past(in_rd, 3) == wb_rd));

    // R4
    every_write_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 3) && $past(in_rd, 3) != '0) |-> wb_valid);

    // R8
    no_zero_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_rd != '0);

    // R8
    zero_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_addr == '0) |-> dbg_data == '0);

    // R10
    commit_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (dbg_addr != $past(wb_rd)) || (dbg_data == $past(wb_data)));

endmodule

bind cmov_pipe cmov_pipe_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_rd    (in_rd),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data),
    .wb_valid (wb_valid),
    .wb_rd    (wb_rd),
    .wb_data  (wb_data)
);

// File: tb/test_cmov_pipe.sv
module test_cmov_pipe;

    localparam int CLK_P  = 10;
    localparam int DATA_W = 32;
    localparam int REG_N  = 8;
    localparam int AW     = 3;

    logic              clk;
    logic              rst_n;
    logic              in_valid;
    logic              in_op;
    logic [AW-1:0]     in_rd;
    logic [AW-1:0]     in_rs;
    logic [AW-1:0]     in_rt;
    logic [AW-1:0]     dbg_addr;
    logic [DATA_W-1:0] dbg_data;
    logic              wb_valid;
    logic [AW-1:0]     wb_rd;
    logic [DATA_W-1:0] wb_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [DATA_W-1:0] model [REG_N];
    logic [AW-1:0]     q_rd  [$];
    logic [DATA_W-1:0] q_val [$];
    string             q_tag [$];

    cmov_pipe #(.DATA_W(DATA_W), .REG_N(REG_N)) i_cmov_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_op    (in_op),
        .in_rd    (in_rd),
        .in_rs    (in_rs),
        .in_rt    (in_rt),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data),
        .wb_valid (wb_valid),
        .wb_rd    (wb_rd),
        .wb_data  (wb_data)
    );

    initial clk = 1'b0;
    always #(CLK_P / 2) clk = ~clk;

    task automatic report_fail(input string tag, input string what,
                               input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: issue one instruction and push its expected commit.
    task automatic issue(input logic op, input int rd, input int rs, input int rt,
                         input string tag);
        logic [DATA_W-1:0] r;
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_rd    = AW'(rd);
        in_rs    = AW'(rs);
        in_rt    = AW'(rt);
        if (op == 1'b0) r = model[rs] + model[rt];
        else            r = (model[rt] == '0) ? model[rs] : model[rd];
        if (rd != 0) begin
            model[rd] = r;
            q_rd.push_back(AW'(rd));
            q_val.push_back(r);
            q_tag.push_back(tag);
        end
    endtask

    // Bubble whose fields describe a move that would overwrite r1 (R9).
    task automatic bubble();
        @(negedge clk);
        in_valid = 1'b0;
        in_op    = 1'b1;
        in_rd    = 3'd1;
        in_rs    = 3'd2;
        in_rt    = 3'd0;
    endtask

    task automatic drain(input string tag);
        repeat (5) bubble();
        checks++;
        if (q_rd.size() != 0)
            report_fail(tag, "missing commits", DATA_W'(q_rd.size()), '0);
        q_rd.delete();
        q_val.delete();
        q_tag.delete();
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < REG_N; i++) begin
            @(negedge clk);
            dbg_addr = AW'(i);
            #1;
            checks++;
            if (dbg_data !== model[i])
                report_fail(tag, $sformatf("debug r%0d", i), dbg_data, model[i]);
        end
    endtask

    // Monitor: compare each retiring write with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && wb_valid === 1'b1) begin
            checks++;
            if (q_rd.size() == 0) begin
                report_fail("R9/R8", "unexpected commit to rd", DATA_W'(wb_rd), '0);
            end else begin
                logic [AW-1:0]     erd;
                logic [DATA_W-1:0] ev;
                string             et;
                erd = q_rd.pop_front();
                ev  = q_val.pop_front();
                et  = q_tag.pop_front();
                if (wb_rd !== erd)
                    report_fail(et, "commit rd", DATA_W'(wb_rd), DATA_W'(erd));
                else if (wb_data !== ev)
                    report_fail(et, "commit data", wb_data, ev);
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        for (int i = 0; i < REG_N; i++) model[i] = DATA_W'(i);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_op    = 1'b0;
        in_rd    = '0;
        in_rs    = '0;
        in_rt    = '0;
        dbg_addr = '0;

        // R1: quiet during reset, index values afterwards.
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (wb_valid !== 1'b0) report_fail("R1", "wb_valid in reset", DATA_W'(wb_valid), '0);
        end
        rst_n = 1'b1;
        check_regs("R1");

        // R2 and R6: add chain with execute and memory forwarding.
        issue(1'b0, 1, 2, 3, "R2");       // r1 = 5
        issue(1'b0, 4, 1, 1, "R2 R6");    // r4 = 10 (near)
        issue(1'b0, 5, 4, 1, "R2 R6");    // r5 = 15 (near + far)
        bubble();
        issue(1'b0, 6, 1, 5, "R6");       // r5 from far
        drain("R2");
        check_regs("R10");

        // R6: same register produced twice in a row, youngest must win.
        issue(1'b0, 2, 2, 2, "R6");
        issue(1'b0, 2, 2, 7, "R6");
        issue(1'b0, 3, 2, 0, "R6 youngest");
        drain("R6");
        check_regs("R6");

        // R7: producer three slots ahead through register-file pass-through.
        issue(1'b0, 7, 1, 1, "R7");
        bubble();
        bubble();
        issue(1'b0, 6, 7, 0, "R7 pass-through");
        drain("R7");
        check_regs("R7");

        // R3 and R5: taken moves; condition itself forwarded.
        issue(1'b1, 5, 1, 0, "R3");
        issue(1'b0, 6, 5, 0, "R5 taken consumer");
        issue(1'b0, 3, 0, 0, "R3");       // r3 = 0
        issue(1'b1, 4, 1, 3, "R3 fwd cond");
        issue(1'b0, 6, 4, 0, "R5 taken consumer");
        drain("R3");
        check_regs("R3");

        // R4 and R5: not-taken moves, old rd forwarded, immediate consumer.
        issue(1'b1, 4, 2, 1, "R4");
        issue(1'b0, 6, 4, 4, "R5 not-taken consumer");
        issue(1'b0, 4, 1, 2, "R4");
        issue(1'b1, 4, 7, 5, "R4 old rd forwarded");
        issue(1'b0, 6, 4, 0, "R5 not-taken consumer");
        issue(1'b1, 1, 2, 0, "R3");
        issue(1'b1, 1, 3, 1, "R4 chained");
        issue(1'b1, 6, 1, 6, "R5 rs from move");
        drain("R4");
        check_regs("R4");

        // R8: writes to r0 dropped, never forwarded.
        issue(1'b0, 0, 1, 1, "R8");
        issue(1'b0, 2, 0, 1, "R8 no forward");
        issue(1'b1, 0, 2, 0, "R8");
        issue(1'b1, 3, 0, 0, "R8 zero rs");
        drain("R8");
        check_regs("R8");

        // R9: bubbles neither commit nor forward.
        issue(1'b0, 1, 2, 2, "R9");
        bubble();
        issue(1'b0, 5, 1, 0, "R9 after bubble");
        bubble();
        bubble();
        issue(1'b0, 6, 1, 5, "R9");
        drain("R9");
        check_regs("R9");

        summary();
    end

endmodule